// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

The block takes a three-wire serial PCM stream (bit clock, word clock or frame sync, data) and turns it into parallel 32-bit sample words in the system clock domain. The three serial lines are oversampled by the system clock. Data is taken on each rising edge of the bit clock. One shift engine serves four framing formats: I2S, left-justified, right-justified, and a TDM/DSP frame-sync mode in which the first two slots of each frame carry the left and right samples.

Word length is chosen from 16, 20, 24 and 32 bits. Each finished sample appears on `data_o`, MSB-aligned and zero-filled below, with a one-cycle `valid_o` strobe and a channel flag. The frame length in bit clocks is not configured. It follows from the word clock: 32, 48 or 64 bit clocks per sample period in the two-channel formats, and 128 or 256 in TDM. Configuration inputs are static while the block runs and change only under reset.

Top module: `audio_serial_rx`

## Requirements
- R1: While `rst_ni` is low, `valid_o` is low and `data_o` and `right_o` are zero.
- R2: The data and word clock lines are sampled on each rising bit clock edge. Each `valid_o` pulse comes exactly two system clocks after the internal bit strobe of the bit that completed the word.
- R3: With `fmt_i`=0 (I2S), the MSB is the bit one bit clock after the word clock changes. A low word clock marks the left channel (`right_o`=0), a high one the right channel (`right_o`=1).
- R4: With `fmt_i`=1 (left-justified), the MSB is the bit sampled together with the word clock change, and the channel mapping is the same as in R3.
- R5: With `fmt_i`=2 (right-justified), the LSB is the last bit before the word clock changes. Bits earlier in the half-frame than the word length are ignored, and `right_o` gives the level the word clock had during that half-frame.
- R6: With `fmt_i`=3 (TDM), a frame starts at the first bit where the frame sync is sampled high after being low, and that bit is the MSB of slot 0. Slots follow back to back at the word length. Slot 0 is output as left, slot 1 as right, and later slots produce no word.
- R7: `wlen_i` selects 16, 20, 24 or 32 bits for codes 0, 1, 2 and 3. Output words are MSB-aligned in 32 bits with all lower bits zero, whatever the line carries after the word.
- R8: In I2S or left-justified mode, if the word clock changes before a full word has arrived, the bits received so far are output MSB-aligned at that change, with zeros below.
- R9: Each completed word gives exactly one single-cycle `valid_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fmt_i | input | 2 | Framing: 0 I2S, 1 left-justified, 2 right-justified, 3 TDM |
| wlen_i | input | 2 | Word length: 0=16, 1=20, 2=24, 3=32 bits |
| sck_i | input | 1 | Serial bit clock (asynchronous) |
| ws_i | input | 1 | Word clock / frame sync (asynchronous) |
| sd_i | input | 1 | Serial data (asynchronous) |
| valid_o | output | 1 | One-cycle strobe for a new word |
| right_o | output | 1 | Channel of the word: 0 left, 1 right |
| data_o | output | 32 | MSB-aligned sample word |

## Verification
The hardest cases to reach sit at the edges of a half-frame. In I2S with 32-bit words at 64 bit clocks per frame, the LSB of each word arrives on the first bit of the next half-frame. With 32-bit words at 32 bit clocks per frame, every word is cut short by the word clock. The bench reaches both by building the serial stream from a left-justified bit pattern: it delays the data line by one bit for I2S, and it uses half-frames shorter than the word for truncation. Filler ones are placed before right-justified words, after left-justified words and in the unused TDM slots. A stray bit taken from any of them would show up as a wrong or extra word.

// File: rtl/audio_rx_pkg.sv
package audio_rx_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned LEN_W  = $clog2(DATA_W + 1);

  typedef enum logic [1:0] {
    FMT_I2S = 2'd0,
    FMT_LJ  = 2'd1,
    FMT_RJ  = 2'd2,
    FMT_TDM = 2'd3
  } fmt_e;

  function automatic logic [LEN_W-1:0] word_len(input logic [1:0] code);
    case (code)
      2'd0:    return LEN_W'(16);
      2'd1:    return LEN_W'(20);
      2'd2:    return LEN_W'(24);
      default: return LEN_W'(32);
    endcase
  endfunction
endpackage

// File: rtl/audio_rx_sync.sv
module audio_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic ws_i,
  input  logic sd_i,
  output logic bit_stb_o,
  output logic ws_o,
  output logic sd_o
);
  localparam int unsigned LINES = 3;

  logic [STAGES-1:0][LINES-1:0] stage_q;
  logic [LINES-1:0]             line_s;
  logic                         sck_prev_q;

  // all three lines share one delay so their alignment is kept
  generate
    if (STAGES > 1) begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q <= '0;
        else         stage_q <= {stage_q[STAGES-2:0], {sck_i, ws_i, sd_i}};
      end
    end else begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q <= '0;
        else         stage_q <= {sck_i, ws_i, sd_i};
      end
    end
  endgenerate

  assign line_s = stage_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_prev_q <= 1'b0;
    else         sck_prev_q <= line_s[2];
  end

  assign bit_stb_o = line_s[2] & ~sck_prev_q;
  assign ws_o      = line_s[1];
  assign sd_o      = line_s[0];
endmodule

// File: rtl/audio_rx_frame.sv
module audio_rx_frame
  import audio_rx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_stb_i,
  input  logic ws_i,
  input  fmt_e fmt_i,
  output logic start_o,
  output logic start_right_o,
  output logic rj_end_o,
  output logic rj_right_o
);
  logic       ws_d1_q, ws_d2_q;
  logic [1:0] fill_q;
  logic       primed, ws_eff, ws_eff_prev, two_ch_edge, fs_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ws_d1_q <= 1'b0;
      ws_d2_q <= 1'b0;
      fill_q  <= '0;
    end else if (bit_stb_i) begin
      ws_d1_q <= ws_i;
      ws_d2_q <= ws_d1_q;
      if (fill_q != 2'd2) fill_q <= fill_q + 2'd1;
    end
  end

  // I2S behaves as left-justified with the word clock one bit late
  always_comb begin
    primed      = (fill_q == 2'd2);
    ws_eff      = (fmt_i == FMT_I2S) ? ws_d1_q : ws_i;
    ws_eff_prev = (fmt_i == FMT_I2S) ? ws_d2_q : ws_d1_q;
    two_ch_edge = ws_eff ^ ws_eff_prev;
    fs_rise     = ws_i & ~ws_d1_q;
  end

  assign start_o       = bit_stb_i & primed & (fmt_i != FMT_RJ) &
                         ((fmt_i == FMT_TDM) ? fs_rise : two_ch_edge);
  assign start_right_o = (fmt_i == FMT_TDM) ? 1'b0 : ws_eff;
  assign rj_end_o      = bit_stb_i & primed & (fmt_i == FMT_RJ) & (ws_i ^ ws_d1_q);
  assign rj_right_o    = ws_d1_q;
endmodule

// File: rtl/audio_rx_shift.sv
module audio_rx_shift
  import audio_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_stb_i,
  input  logic              sd_i,
  input  fmt_e              fmt_i,
  input  logic [LEN_W-1:0]  wlen_i,
  input  logic              start_i,
  input  logic              start_right_i,
  input  logic              rj_end_i,
  input  logic              rj_right_i,
  output logic              emit_o,
  output logic [DATA_W-1:0] word_o,
  output logic [LEN_W-1:0]  nbits_o,
  output logic              right_o
);
  logic [DATA_W-1:0] sr_q, sr_next;
  logic [LEN_W-1:0]  cnt_q, cnt_inc;
  logic              active_q, chan_q;

  always_comb begin
    sr_next = {sr_q[DATA_W-2:0], sd_i};
    cnt_inc = cnt_q + LEN_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q     <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
      chan_q   <= 1'b0;
      emit_o   <= 1'b0;
      word_o   <= '0;
      nbits_o  <= '0;
      right_o  <= 1'b0;
    end else begin
      emit_o <= 1'b0;
      if (bit_stb_i) begin
        if (fmt_i == FMT_RJ) begin
          // free-running shift, last wlen bits taken at the edge
          sr_q <= sr_next;
          if (rj_end_i) begin
            emit_o  <= 1'b1;
            word_o  <= sr_q;
            nbits_o <= wlen_i;
            right_o <= rj_right_i;
          end
        end else if (start_i) begin
          if (active_q && cnt_q != '0) begin
            emit_o  <= 1'b1;
            word_o  <= sr_q;
            nbits_o <= cnt_q;
            right_o <= chan_q;
          end
          sr_q     <= sr_next;
          cnt_q    <= LEN_W'(1);
          chan_q   <= start_right_i;
          active_q <= 1'b1;
        end else if (active_q) begin
          sr_q <= sr_next;
          if (cnt_inc >= wlen_i) begin
            emit_o  <= 1'b1;
            word_o  <= sr_next;
            nbits_o <= wlen_i;
            right_o <= chan_q;
            cnt_q   <= '0;
            if (fmt_i == FMT_TDM && !chan_q) chan_q   <= 1'b1;
            else                             active_q <= 1'b0;
          end else begin
            cnt_q <= cnt_inc;
          end
        end
      end
    end
  end
endmodule

// File: rtl/audio_rx_align.sv
module audio_rx_align
  import audio_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              emit_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic [LEN_W-1:0]  nbits_i,
  input  logic              right_i,
  output logic              valid_o,
  output logic              right_o,
  output logic [DATA_W-1:0] data_o
);
  localparam logic [LEN_W-1:0] FULL = LEN_W'(DATA_W);

  logic [LEN_W-1:0] sh_amt;
  assign sh_amt = FULL - nbits_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      right_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= emit_i;
      if (emit_i) begin
        right_o <= right_i;
        data_o  <= word_i << sh_amt;
      end
    end
  end
endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
  import audio_rx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        fmt_i,
  input  logic [1:0]        wlen_i,
  input  logic              sck_i,
  input  logic              ws_i,
  input  logic              sd_i,
  output logic              valid_o,
  output logic              right_o,
  output logic [DATA_W-1:0] data_o
);
  fmt_e              fmt;
  logic [LEN_W-1:0]  wlen_n;
  logic              bit_stb, ws_s, sd_s;
  logic              start, start_right, rj_end, rj_right;
  logic              emit, emit_right;
  logic [DATA_W-1:0] emit_word;
  logic [LEN_W-1:0]  emit_n;

  assign fmt    = fmt_e'(fmt_i);
  assign wlen_n = word_len(wlen_i);

  audio_rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .sck_i, .ws_i, .sd_i,
    .bit_stb_o(bit_stb), .ws_o(ws_s), .sd_o(sd_s)
  );

  audio_rx_frame i_frame (
    .clk_i, .rst_ni, .bit_stb_i(bit_stb), .ws_i(ws_s), .fmt_i(fmt),
    .start_o(start), .start_right_o(start_right),
    .rj_end_o(rj_end), .rj_right_o(rj_right)
  );

  audio_rx_shift i_shift (
    .clk_i, .rst_ni, .bit_stb_i(bit_stb), .sd_i(sd_s), .fmt_i(fmt),
    .wlen_i(wlen_n), .start_i(start), .start_right_i(start_right),
    .rj_end_i(rj_end), .rj_right_i(rj_right),
    .emit_o(emit), .word_o(emit_word), .nbits_o(emit_n), .right_o(emit_right)
  );

  audio_rx_align i_align (
    .clk_i, .rst_ni, .emit_i(emit), .word_i(emit_word), .nbits_i(emit_n),
    .right_i(emit_right), .valid_o, .right_o, .data_o
  );
endmodule

// File: rtl/audio_serial_rx_chk.sv
module audio_serial_rx_chk
  import audio_rx_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        wlen_i,
  input logic              bit_stb_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] low_mask;
  assign low_mask = {DATA_W{1'b1}} >> word_len(wlen_i);

  p_reset_quiet_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && data_o == '0));

  p_on_strobe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(bit_stb_i, 2));

  p_zero_fill_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((data_o & low_mask) == '0));

  p_single_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
endmodule

bind audio_serial_rx audio_serial_rx_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wlen_i(wlen_i),
  .bit_stb_i(bit_stb), .valid_o(valid_o), .data_o(data_o)
);

// File: tb/test_audio_serial_rx.sv
module test_audio_serial_rx;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b1;
  logic [1:0]  fmt_i = 2'd1, wlen_i = 2'd3;
  logic        sck_i = 1'b0, ws_i = 1'b0, sd_i = 1'b0;
  logic        valid_o, right_o;
  logic [31:0] data_o;

  int n_chk = 0, n_bad = 0;
  logic [31:0] log_d [512];
  logic        log_r [512];
  int          log_n = 0;

  always #2 clk = ~clk;

  audio_serial_rx i_audio_serial_rx (
    .clk_i(clk), .rst_ni, .fmt_i, .wlen_i, .sck_i, .ws_i, .sd_i,
    .valid_o, .right_o, .data_o
  );

  always @(negedge clk) begin
    if (valid_o && log_n < 512) begin
      log_d[log_n] = data_o;
      log_r[log_n] = right_o;
      log_n++;
    end
  end

  function automatic int wbits(input logic [1:0] c);
    case (c) 2'd0: return 16; 2'd1: return 20; 2'd2: return 24; default: return 32; endcase
  endfunction

  function automatic logic [31:0] top_mask(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ~(32'hFFFF_FFFF >> n);
  endfunction

  function automatic logic [31:0] mk(input int seed, input int f, input int ch);
    return 32'h8000_0000 | (32'h1357_9BDF * (seed * 8 + f * 2 + ch + 1));
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic w, input logic d);
    @(negedge clk);
    sck_i = 1'b0; ws_i = w; sd_i = d;
    repeat (3) @(negedge clk);
    sck_i = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_reset(input logic [1:0] f, input logic [1:0] w);
    @(negedge clk);
    rst_ni = 1'b0; sck_i = 1'b0; ws_i = 1'b0; sd_i = 1'b0;
    fmt_i = f; wlen_i = w;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // compare expected words as a consecutive run in the log
  task automatic match_run(input int base, input logic [31:0] ev [8], input logic er [8],
                           input int ne, input string tag, output int j);
    j = -1;
    for (int k = base; k < log_n; k++)
      if (j < 0 && log_d[k] == ev[0] && log_r[k] == er[0]) j = k;
    if (j < 0) chk(1'b0, tag, 32'h0, ev[0]);
    else
      for (int k = 0; k < ne; k++) begin
        if (j + k < log_n)
          chk(log_d[j+k] == ev[k] && log_r[j+k] == er[k], tag,
              {log_d[j+k][31:1], log_r[j+k]} ^ 32'h0 | log_d[j+k], ev[k]);
        else
          chk(1'b0, tag, 32'hDEAD_0000, ev[k]);
      end
  endtask

  // lead and trailing frames carry zero; n real frames between them
  task automatic play_stereo(input logic [1:0] f, input logic [1:0] wc, input int h,
                             input int n, input int seed, input string tag);
    logic [31:0] ev [8];
    logic        er [8];
    logic        prev, b;
    int          w, e, idx, base, j;
    w = wbits(wc); e = (w < h) ? w : h;
    do_reset(f, wc);
    base = log_n; prev = 1'b1; idx = 0;
    for (int fr = 0; fr <= n + 1; fr++)
      for (int ch = 0; ch < 2; ch++) begin
        logic [31:0] v;
        v = (fr == 0 || fr == n + 1) ? 32'h0 : mk(seed, fr, ch);
        if (fr != 0 && fr != n + 1) begin
          ev[idx] = v & top_mask(e); er[idx] = ch[0]; idx++;
        end
        for (int i = 0; i < h; i++) begin
          if (f == 2'd2) b = (i >= h - w) ? v[31 - (i - (h - w))] : 1'b1;
          else           b = (i < w) ? v[31 - i] : 1'b1;
          if (f == 2'd0) begin send_bit(ch[0], prev); prev = b; end
          else           send_bit(ch[0], b);
        end
      end
    repeat (20) @(negedge clk);
    match_run(base, ev, er, 2 * n, tag, j);
  endtask

  task automatic play_tdm(input logic [1:0] wc, input int fb, input int n,
                          input int seed, input string tag);
    logic [31:0] ev [8];
    logic        er [8];
    int          w, base, j, idx;
    w = wbits(wc);
    do_reset(2'd3, wc);
    base = log_n; idx = 0;
    for (int fr = 0; fr <= n; fr++) begin
      logic [31:0] l, r, x;
      l = (fr == 0) ? 32'h0 : mk(seed, fr, 0);
      r = (fr == 0) ? 32'h0 : mk(seed, fr, 1);
      x = mk(seed + 5, fr, 0);
      if (fr != 0) begin
        ev[idx] = l & top_mask(w); er[idx] = 1'b0; idx++;
        ev[idx] = r & top_mask(w); er[idx] = 1'b1; idx++;
      end
      for (int bi = 0; bi < fb; bi++) begin
        int s, k;
        logic d;
        s = bi / w; k = bi % w;
        d = (s == 0) ? l[31-k] : (s == 1) ? r[31-k] : (s == 2) ? x[31-k] : 1'b1;
        send_bit(bi == 0, d);
      end
    end
    for (int i = 0; i < 8; i++) send_bit(1'b0, 1'b1);
    repeat (20) @(negedge clk);
    match_run(base, ev, er, 2 * n, tag, j);
    // slots beyond the second must add no words
    chk(j >= 0 && log_n == j + 2 * n, {tag, " slot count R6"}, 32'(log_n), 32'(j + 2 * n));
  endtask

  task automatic t_reset;
    @(negedge clk); rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk(!valid_o, "R1 valid", {31'b0, valid_o}, 32'h0);
    chk(data_o == 32'h0, "R1 data", data_o, 32'h0);
    chk(!right_o, "R1 right", {31'b0, right_o}, 32'h0);
    rst_ni = 1'b1;
  endtask

  task automatic t_lj24;      play_stereo(2'd1, 2'd2, 32, 3, 1, "R4 R7 R2 LJ 24b 64fs");  endtask
  task automatic t_lj20_48;   play_stereo(2'd1, 2'd1, 24, 2, 2, "R4 R7 LJ 20b 48fs");     endtask
  task automatic t_i2s16;     play_stereo(2'd0, 2'd0, 16, 3, 3, "R3 R7 I2S 16b 32fs");    endtask
  task automatic t_i2s32;     play_stereo(2'd0, 2'd3, 32, 3, 4, "R3 R9 I2S 32b 64fs");    endtask
  task automatic t_rj20;      play_stereo(2'd2, 2'd1, 24, 3, 5, "R5 RJ 20b 48fs");        endtask
  task automatic t_rj16;      play_stereo(2'd2, 2'd0, 32, 2, 6, "R5 R7 RJ 16b 64fs");     endtask
  task automatic t_lj_trunc;  play_stereo(2'd1, 2'd3, 16, 3, 7, "R8 LJ 32b 32fs");        endtask
  task automatic t_i2s_trunc; play_stereo(2'd0, 2'd2, 16, 2, 8, "R8 I2S 24b 32fs");       endtask
  task automatic t_tdm32;     play_tdm(2'd3, 128, 2, 9,  "R6 TDM 32b 128");              endtask
  task automatic t_tdm16;     play_tdm(2'd0, 256, 2, 10, "R6 R7 TDM 16b 256");           endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1 rst_ni = 1'b0;
    t_reset();
    t_lj24();
    t_lj20_48();
    t_i2s16();
    t_i2s32();
    t_rj20();
    t_rj16();
    t_lj_trunc();
    t_i2s_trunc();
    t_tdm32();
    t_tdm16();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule